// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block moves a set of generated output clocks, a PLL oscillator enable and a crystal oscillator enable into and out of a low-power state in response to an asynchronous, active-low power-down request. The request first passes through a synchronizer clocked by a free-running reference clock. Each output clock then finishes any high phase it is in and parks low, so no high pulse is ever shortened. Only when every output is parked are the PLL and crystal enables dropped, and no output divider advances while the block is powered down.

When the request is released, the block re-enables the crystal and waits a programmable settle count. It then enables the PLL and waits a second programmable count. Finally it ungates the output dividers, and each output starts with a full low phase. The worst-case power-up latency is therefore fixed by the two settle counts plus a few synchronizer and sequencing cycles. If the request is released before the outputs have finished parking, the block completes the power-down first and only then starts the power-up order.

Output clocks are modelled as dividers of the reference clock. Output `i` has a half-period of `BASE_HALF*(i+1)` reference cycles. Oscillator behaviour is represented by the two enable outputs only.

Top module: `pdseq_top`

## Requirements
- R1: `pd_req_n` is synchronized through two flip-flop stages; after it is driven low ahead of reference edge 1, `ready` is low from the third rising edge on.
- R2: Every high phase of `clk_out[i]` lasts exactly `BASE_HALF*(i+1)` reference cycles, including the last high phase before a stop.
- R3: Once power-down starts, every output ends low, and `parked` rises no later than `3 + BASE_HALF*N_OUT` cycles after the request. While parked, no output toggles.
- R4: `xtal_en` and `pll_en` both fall exactly one cycle after `parked` first rises, and they stay low while the request is held. Whenever either enable is low, all outputs are low.
- R5: After release, `xtal_en` rises on edge 3 and `pll_en` rises on edge `4 + xtal_settle`. `ready` rises on edge `5 + xtal_settle + pll_settle`, all counted from the release.
- R6: After ungating, output `i` first goes high exactly `BASE_HALF*(i+1)` cycles after `ready` rises, which gives it a full low phase first.
- R7: A release that arrives during parking does not skip the off state. `xtal_en` goes low for at least one cycle, and `ready` rises `xtal_settle + pll_settle + 2` cycles after `xtal_en` rises again.
- R8: During reset all outputs are low, `xtal_en`, `pll_en` and `ready` are high, and `parked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| xtal_settle | input | CNT_W | Crystal settle count (waits value+1 cycles) |
| pll_settle | input | CNT_W | PLL settle count (waits value+1 cycles) |
| clk_out | output | N_OUT | Gated output clocks |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL oscillator enable |
| parked | output | 1 | All outputs stopped low and dividers gated |
| ready | output | 1 | Power-up complete, outputs running |

## Verification
The hardest case to reach from the ports is a release that lands while the block is still parking, with at least one slow output partway through its final high phase. The bench reaches it by asserting the request at sixteen different offsets against the free-running dividers and releasing it two cycles later. For each offset it checks that the oscillators still drop before power-up, and that the ready latency is measured from the crystal re-enable. The settle counts are swept across a small grid, and each phase of the power-up order is timed against arithmetic expectations.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PARK,
        ST_OFF,
        ST_XTAL,
        ST_PLL
    } seq_state_e;

    typedef struct packed {
        logic xtal_en;
        logic pll_en;
        logic run;
    } osc_ctl_t;

    function automatic int unsigned half_period(int unsigned base, int unsigned idx);
        return base * (idx + 1);
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/pdseq_clkgate.sv
module pdseq_clkgate #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic clk_o,
    output logic parked
);
    localparam int unsigned CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          phase;

    // A high phase always completes; a low phase is cut short only by gating.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (run || phase) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign clk_o  = phase;
    assign parked = ~run & ~phase;

    // R3
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !phase) |=> !phase);

    // R2
    rise_only_running_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phase) |-> $past(run));

    // R2
    high_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_active,
    input  logic             all_parked,
    input  logic [CNT_W-1:0] xtal_settle,
    input  logic [CNT_W-1:0] pll_settle,
    output osc_ctl_t         ctl,
    output logic             ready
);
    seq_state_e       state;
    logic [CNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            wcnt  <= '0;
        end else begin
            unique case (state)
                ST_RUN:  if (pd_active) state <= ST_PARK;
                ST_PARK: if (all_parked) state <= ST_OFF;
                ST_OFF: begin
                    wcnt <= '0;
                    if (!pd_active) state <= ST_XTAL;
                end
                ST_XTAL: begin
                    if (wcnt == xtal_settle) begin
                        wcnt  <= '0;
                        state <= ST_PLL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_PLL: begin
                    if (wcnt == pll_settle) begin
                        wcnt  <= '0;
                        state <= ST_RUN;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        ctl.run     = (state == ST_RUN);
        ctl.xtal_en = (state != ST_OFF);
        ctl.pll_en  = (state == ST_RUN) || (state == ST_PARK) || (state == ST_PLL);
    end

    assign ready = ctl.run;

    // R4
    osc_off_parked_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.xtal_en || !ctl.pll_en) |-> all_parked);

    // R5
    pll_after_xtal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.pll_en) |-> $past(ctl.xtal_en));
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int unsigned N_OUT       = 4,
    parameter int unsigned BASE_HALF   = 2,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req_n,
    input  logic [CNT_W-1:0] xtal_settle,
    input  logic [CNT_W-1:0] pll_settle,
    output logic [N_OUT-1:0] clk_out,
    output logic             xtal_en,
    output logic             pll_en,
    output logic             parked,
    output logic             ready
);
    logic             req_sync_n;
    logic [N_OUT-1:0] park_vec;
    osc_ctl_t         ctl;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pd_req_n),
        .q   (req_sync_n)
    );

    pdseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pd_active   (~req_sync_n),
        .all_parked  (parked),
        .xtal_settle (xtal_settle),
        .pll_settle  (pll_settle),
        .ctl         (ctl),
        .ready       (ready)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        pdseq_clkgate #(.HALF(half_period(BASE_HALF, g))) u_gate (
            .clk    (clk),
            .rst    (rst),
            .run    (ctl.run),
            .clk_o  (clk_out[g]),
            .parked (park_vec[g])
        );
    end

    assign parked  = &park_vec;
    assign xtal_en = ctl.xtal_en;
    assign pll_en  = ctl.pll_en;

    // R6
    ungate_from_parked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(parked) && $past(clk_out) == '0));

    // R7
    xtal_after_park_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xtal_en) |-> $past(parked));
endmodule

// File: tb/pdseq_top_tb.sv
module pdseq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_OUT = 4;
    localparam int BASE_HALF = 2;
    localparam int CNT_W = 8;
    localparam int HP_MAX = BASE_HALF * N_OUT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req_n = 1'b1;
    logic [CNT_W-1:0] xtal_settle = '0;
    logic [CNT_W-1:0] pll_settle = '0;
    logic [N_OUT-1:0] clk_out;
    logic xtal_en, pll_en, parked, ready;

    int checks = 0;
    int errors = 0;
    int mon_r2 = 0;
    int mon_r4 = 0;
    int mon_r3 = 0;
    bit done = 1'b0;

    pdseq_top #(.N_OUT(N_OUT), .BASE_HALF(BASE_HALF), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n),
        .xtal_settle(xtal_settle), .pll_settle(pll_settle),
        .clk_out(clk_out), .xtal_en(xtal_en), .pll_en(pll_en),
        .parked(parked), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int hp(int i);
        return BASE_HALF * (i + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Continuous monitors sampled at falling edges
    int hrun [N_OUT];
    logic [N_OUT-1:0] prev_out = '0;
    logic prev_parked = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OUT; i++) hrun[i] = 0;
            prev_parked = 1'b0;
        end else begin
            for (int i = 0; i < N_OUT; i++) begin
                if (clk_out[i]) hrun[i]++;
                else if (hrun[i] != 0) begin
                    if (hrun[i] != hp(i)) begin
                        mon_r2++;
                        $display("FAIL R2: out%0d high width actual %0d expected %0d", i, hrun[i], hp(i));
                    end
                    hrun[i] = 0;
                end
            end
            if ((!xtal_en || !pll_en) && clk_out != '0) begin
                mon_r4++;
                $display("FAIL R4: outputs actual %0d expected 0 with oscillators off", clk_out);
            end
            if (prev_parked && parked && clk_out != prev_out) begin
                mon_r3++;
                $display("FAIL R3: outputs toggled while parked actual %0d expected %0d", clk_out, prev_out);
            end
            prev_parked = parked;
            prev_out = clk_out;
        end
    end

    // Full power-down / power-up cycle with timing checks
    task automatic full_cycle(input int xs, input int ps, input int pre);
        int t, t_rdy, t_park, t_off, tx, tp, tr;
        int first_hi [N_OUT];
        @(negedge clk);
        xtal_settle = CNT_W'(xs);
        pll_settle = CNT_W'(ps);
        repeat (pre) @(negedge clk);
        pd_req_n = 1'b0;
        t = 0; t_rdy = -1; t_park = -1; t_off = -1;
        while (t < 40 && t_off < 0) begin
            @(posedge clk); t++; @(negedge clk);
            if (t_rdy < 0 && !ready) t_rdy = t;
            if (t_park < 0 && parked) t_park = t;
            if (t_off < 0 && !xtal_en && !pll_en) t_off = t;
        end
        // R1
        check(t_rdy == 3, "R1 ready drop edge", t_rdy, 3);
        // R3
        check(t_park > 0 && t_park <= 3 + HP_MAX, "R3 parked latency", t_park, 3 + HP_MAX);
        // R4
        check(t_off == t_park + 1, "R4 oscillators off edge", t_off, t_park + 1);
        repeat (20) @(negedge clk);
        // R4
        check(!xtal_en && !pll_en && clk_out == '0 && parked, "R4 held off",
              {xtal_en, pll_en, parked}, 3'b001);
        pd_req_n = 1'b1;
        t = 0; tx = -1; tp = -1; tr = -1;
        while (t < 600 && tr < 0) begin
            @(posedge clk); t++; @(negedge clk);
            if (tx < 0 && xtal_en) tx = t;
            if (tp < 0 && pll_en) tp = t;
            if (tr < 0 && ready) tr = t;
        end
        // R5
        check(tx == 3, "R5 xtal enable edge", tx, 3);
        check(tp == 4 + xs, "R5 pll enable edge", tp, 4 + xs);
        check(tr == 5 + xs + ps, "R5 ready edge", tr, 5 + xs + ps);
        for (int i = 0; i < N_OUT; i++) first_hi[i] = -1;
        t = 0;
        while (t < 2 * HP_MAX) begin
            @(posedge clk); t++; @(negedge clk);
            for (int i = 0; i < N_OUT; i++)
                if (first_hi[i] < 0 && clk_out[i]) first_hi[i] = t;
        end
        for (int i = 0; i < N_OUT; i++)
            // R6
            check(first_hi[i] == hp(i), "R6 first rise after ungate", first_hi[i], hp(i));
    endtask

    // Release arriving while parking is still in progress
    task automatic abort_cycle(input int xs, input int ps, input int pre);
        int t, tx, tr;
        bit saw_off;
        @(negedge clk);
        xtal_settle = CNT_W'(xs);
        pll_settle = CNT_W'(ps);
        repeat (pre) @(negedge clk);
        pd_req_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pd_req_n = 1'b1;
        t = 0; tx = -1; tr = -1; saw_off = 1'b0;
        while (t < 700 && tr < 0) begin
            @(posedge clk); t++; @(negedge clk);
            if (!xtal_en) saw_off = 1'b1;
            if (saw_off && tx < 0 && xtal_en) tx = t;
            if (tx >= 0 && tr < 0 && ready) tr = t;
        end
        // R7
        check(saw_off, "R7 off state reached", saw_off, 1);
        check(tr - tx == xs + ps + 2, "R7 ready after xtal", tr - tx, xs + ps + 2);
        repeat (2 * HP_MAX) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8
        check(clk_out == '0, "R8 reset outputs", clk_out, 0);
        check(xtal_en && pll_en && ready && !parked, "R8 reset status",
              {xtal_en, pll_en, ready, parked}, 4'b1110);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        foreach (hrun[k]) hrun[k] = hrun[k];
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 3; b++) begin
                int xs_v, ps_v;
                xs_v = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 3 : 7;
                ps_v = (b == 0) ? 0 : (b == 1) ? 2 : 5;
                full_cycle(xs_v, ps_v, (xs_v + ps_v) % 8);
            end
        end
        for (int d = 0; d < 16; d++) abort_cycle(d % 3, (d + 1) % 4, d);
        repeat (20) @(negedge clk);
        // R2
        check(mon_r2 == 0, "R2 high widths", mon_r2, 0);
        // R4
        check(mon_r4 == 0, "R4 outputs low while off", mon_r4, 0);
        // R3
        check(mon_r3 == 0, "R3 no toggle while parked", mon_r3, 0);
        finish_run();
    end
endmodule